// File: doc/BRIEF.md
# Two-Operand Accumulator Datapath

This block executes one 24-bit instruction word per clock against a bank of four 16-bit registers, a word-addressed data memory port and a small arithmetic unit. The register named by the A field is both the first operand and the destination of every arithmetic, shift and load result. There is no separate result bus. The register named by the B field supplies the second operand, a memory address, or the destination of a move.

Each instruction is presented on `instr` for a full cycle. Decode, register reads, memory reads and the arithmetic are combinational within that cycle. The register write and any memory write take effect on the rising clock edge that ends the cycle. Two operand buses, `bus_a` and `bus_b`, show the value on each register port. A strobe per bus tells whether that bus carries a value being written into the register bank or a value read out of it. Branch instructions are decoded only to keep the block quiet. A separate sequencer uses `bus_a` as the jump target and `b_is_zero` as the condition.

Top module: `acc_datapath`

## Requirements
- R1: While `rst_n` is low, all four registers are cleared to zero.
- R2: The instruction layout is opcode in bits 23..19, A select in bits 18..17, B select in bits 16..15 and a 15-bit immediate in bits 14..0. When neither register is being written, `bus_a` shows the register picked by the A select and `bus_b` shows the register picked by the B select.
- R3: LD (opcode 1) writes the memory word at the immediate address into A. LDR (opcode 2) writes the memory word at the address held in B into A.
- R4: ST (5) writes the zero-extended immediate to memory at address B. STR (6) writes A to memory at address B. STD (7) writes A to memory at the immediate address. `mem_we` is high only for these three opcodes.
- R5: MOV (3) copies A into B. MOVD (4) writes the immediate, zero-extended to 16 bits, into B.
- R6: ALU (8) writes A op B into A, with op taken from immediate bits 2..0: 0 add, 1 subtract (A minus B), 2 and, 3 or, 4 xor, 5 not A. Codes 6 and 7 leave A unchanged. Sums and differences wrap modulo 2^16.
- R7: SR (9) shifts A right by one bit and SL (10) shifts A left by one bit, both with a zero fill, and the result goes to A.
- R8: `a_wr` is high exactly for opcodes 1, 2, 8, 9 and 10, and `b_wr` is high exactly for opcodes 3 and 4. The two strobes are never high together. While a strobe is high, its bus carries the value committed to that register at the next rising edge.
- R9: NOP (0), the jump opcodes 11..16 and undefined opcodes 17..31 write no register and no memory. For every opcode, `b_is_zero` is high exactly when the register read through the B port holds zero.
- R10: An address taken from register B uses its low 15 bits, so bit 15 of B has no effect on the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commits occur on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 24 | Instruction word for the current cycle |
| mem_addr | output | 15 | Data memory word address |
| mem_wdata | output | 16 | Data memory write word |
| mem_we | output | 1 | Data memory write enable |
| mem_re | output | 1 | Data memory read request (loads) |
| mem_rdata | input | 16 | Data memory read word, valid in the same cycle |
| bus_a | output | 16 | A port value: read data, or write data when `a_wr` is high |
| bus_b | output | 16 | B port value: read data, or write data when `b_wr` is high |
| a_wr | output | 1 | A bus is being written into the register bank |
| b_wr | output | 1 | B bus is being written into the register bank |
| b_is_zero | output | 1 | Register read on the B port equals zero |

## Verification
A corrupted register shows up on `bus_a` or `bus_b` in the first cycle that selects it. It also shows up as a wrong address or a wrong `b_is_zero` whenever it serves as a B operand. A wrong write strobe or a wrong write selection shows up one cycle later, when a NOP reads the affected register back. A bad memory enable shows up as an altered memory word after the next rising edge. Every check therefore observes an effect at most one instruction after its cause.

// File: rtl/cpu_dp_pkg.sv
package cpu_dp_pkg;

  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 15;
  localparam int INSTR_W  = 24;
  localparam int OPC_W    = 5;
  localparam int SEL_W    = 2;
  localparam int NUM_REGS = 1 << SEL_W;
  localparam int FN_W     = 3;

  // field positions, derived from the top of the word downwards
  localparam int OPC_LSB  = INSTR_W - OPC_W;
  localparam int SELA_LSB = OPC_LSB - SEL_W;
  localparam int SELB_LSB = SELA_LSB - SEL_W;
  localparam int IMM_W    = SELB_LSB;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP    = 5'd0,
    OP_LD     = 5'd1,
    OP_LDR    = 5'd2,
    OP_MOV    = 5'd3,
    OP_MOVD   = 5'd4,
    OP_ST     = 5'd5,
    OP_STR    = 5'd6,
    OP_STD    = 5'd7,
    OP_ALU    = 5'd8,
    OP_SR     = 5'd9,
    OP_SL     = 5'd10,
    OP_JMP    = 5'd11,
    OP_JMPR   = 5'd12,
    OP_JMPZ   = 5'd13,
    OP_JMPRZ  = 5'd14,
    OP_JMPNZ  = 5'd15,
    OP_JMPRNZ = 5'd16
  } opcode_e;

  typedef enum logic [FN_W-1:0] {
    FN_ADD  = 3'd0,
    FN_SUB  = 3'd1,
    FN_AND  = 3'd2,
    FN_OR   = 3'd3,
    FN_XOR  = 3'd4,
    FN_NOTA = 3'd5
  } alu_fn_e;

  typedef enum logic [1:0] {
    ASRC_MEM,
    ASRC_ALU,
    ASRC_SHR,
    ASRC_SHL
  } a_src_e;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [SEL_W-1:0]  sel_a;
    logic [SEL_W-1:0]  sel_b;
    logic [IMM_W-1:0]  imm;
  } instr_t;

  typedef struct packed {
    logic   a_we;
    logic   b_we;
    a_src_e a_src;
    logic   b_from_imm;
    logic   mem_we;
    logic   mem_re;
    logic   addr_from_b;
    logic   wdata_from_imm;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] zext_imm(input logic [IMM_W-1:0] v);
    return {{(DATA_W-IMM_W){1'b0}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] alu_eval(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b,
                                                 input logic [FN_W-1:0]   fn);
    logic [DATA_W-1:0] r;
    case (alu_fn_e'(fn))
      FN_ADD:  r = a + b;
      FN_SUB:  r = a - b;
      FN_AND:  r = a & b;
      FN_OR:   r = a | b;
      FN_XOR:  r = a ^ b;
      FN_NOTA: r = ~a;
      default: r = a;
    endcase
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] shr1(input logic [DATA_W-1:0] a);
    return {1'b0, a[DATA_W-1:1]};
  endfunction

  function automatic logic [DATA_W-1:0] shl1(input logic [DATA_W-1:0] a);
    return {a[DATA_W-2:0], 1'b0};
  endfunction

endpackage

// File: rtl/dp_decode.sv
module dp_decode
  import cpu_dp_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output ctrl_t            ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.a_src = ASRC_MEM;
    case (opcode_e'(opc))
      OP_LD: begin
        ctrl.a_we   = 1'b1;
        ctrl.a_src  = ASRC_MEM;
        ctrl.mem_re = 1'b1;
      end
      OP_LDR: begin
        ctrl.a_we        = 1'b1;
        ctrl.a_src       = ASRC_MEM;
        ctrl.mem_re      = 1'b1;
        ctrl.addr_from_b = 1'b1;
      end
      OP_MOV: begin
        ctrl.b_we = 1'b1;
      end
      OP_MOVD: begin
        ctrl.b_we       = 1'b1;
        ctrl.b_from_imm = 1'b1;
      end
      OP_ST: begin
        ctrl.mem_we         = 1'b1;
        ctrl.addr_from_b    = 1'b1;
        ctrl.wdata_from_imm = 1'b1;
      end
      OP_STR: begin
        ctrl.mem_we      = 1'b1;
        ctrl.addr_from_b = 1'b1;
      end
      OP_STD: begin
        ctrl.mem_we = 1'b1;
      end
      OP_ALU: begin
        ctrl.a_we  = 1'b1;
        ctrl.a_src = ASRC_ALU;
      end
      OP_SR: begin
        ctrl.a_we  = 1'b1;
        ctrl.a_src = ASRC_SHR;
      end
      OP_SL: begin
        ctrl.a_we  = 1'b1;
        ctrl.a_src = ASRC_SHL;
      end
      default: ctrl = ctrl;  // NOP, branches and undefined codes: no effect here
    endcase
  end

endmodule

// File: rtl/dp_regfile.sv
module dp_regfile
  import cpu_dp_pkg::*;
#(
  parameter int W    = DATA_W,
  parameter int SELW = SEL_W,
  localparam int N   = 1 << SELW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SELW-1:0]      sel_a,
  input  logic [SELW-1:0]      sel_b,
  input  logic                 we_a,
  input  logic                 we_b,
  input  logic [W-1:0]         wd_a,
  input  logic [W-1:0]         wd_b,
  output logic [W-1:0]         rd_a,
  output logic [W-1:0]         rd_b,
  output logic [N-1:0][W-1:0]  view
);

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic hit_a, hit_b;
    assign hit_a = we_a && (sel_a == SELW'(i));
    assign hit_b = we_b && (sel_b == SELW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        view[i] <= '0;
      else if (hit_a)
        view[i] <= wd_a;
      else if (hit_b)
        view[i] <= wd_b;
    end
  end

  assign rd_a = view[sel_a];
  assign rd_b = view[sel_b];

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import cpu_dp_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [FN_W-1:0] fn,
  input  a_src_e          sel,
  input  logic [W-1:0]    mem_word,
  output logic [W-1:0]    result
);

  logic [W-1:0] r_alu, r_shr, r_shl;

  assign r_alu = alu_eval(a, b, fn);
  assign r_shr = shr1(a);
  assign r_shl = shl1(a);

  always_comb begin
    case (sel)
      ASRC_ALU: result = r_alu;
      ASRC_SHR: result = r_shr;
      ASRC_SHL: result = r_shl;
      default:  result = mem_word;
    endcase
  end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import cpu_dp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [INSTR_W-1:0]  instr,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                mem_we,
  output logic                mem_re,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [DATA_W-1:0]   bus_a,
  output logic [DATA_W-1:0]   bus_b,
  output logic                a_wr,
  output logic                b_wr,
  output logic                b_is_zero
);

  instr_t                          fld;
  ctrl_t                           ctrl;
  logic [DATA_W-1:0]               rd_a, rd_b;
  logic [DATA_W-1:0]               a_wdata, b_wdata;
  logic [NUM_REGS-1:0][DATA_W-1:0] reg_view;

  // named events for the checker
  logic ev_a_write, ev_b_write, ev_mem_write;

  assign fld = instr_t'(instr);

  dp_decode u_dec (
    .opc  (fld.opc),
    .ctrl (ctrl)
  );

  dp_regfile #(.W(DATA_W), .SELW(SEL_W)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_a (fld.sel_a),
    .sel_b (fld.sel_b),
    .we_a  (ctrl.a_we),
    .we_b  (ctrl.b_we),
    .wd_a  (a_wdata),
    .wd_b  (b_wdata),
    .rd_a  (rd_a),
    .rd_b  (rd_b),
    .view  (reg_view)
  );

  dp_alu #(.W(DATA_W)) u_alu (
    .a        (rd_a),
    .b        (rd_b),
    .fn       (fld.imm[FN_W-1:0]),
    .sel      (ctrl.a_src),
    .mem_word (mem_rdata),
    .result   (a_wdata)
  );

  assign b_wdata   = ctrl.b_from_imm ? zext_imm(fld.imm) : rd_a;

  assign mem_addr  = ctrl.addr_from_b ? rd_b[ADDR_W-1:0] : fld.imm;
  assign mem_wdata = ctrl.wdata_from_imm ? zext_imm(fld.imm) : rd_a;
  assign mem_we    = ctrl.mem_we;
  assign mem_re    = ctrl.mem_re;

  assign a_wr      = ctrl.a_we;
  assign b_wr      = ctrl.b_we;
  assign bus_a     = ctrl.a_we ? a_wdata : rd_a;
  assign bus_b     = ctrl.b_we ? b_wdata : rd_b;
  assign b_is_zero = (rd_b == '0);

  assign ev_a_write   = ctrl.a_we;
  assign ev_b_write   = ctrl.b_we;
  assign ev_mem_write = ctrl.mem_we;

endmodule

// File: rtl/acc_datapath_chk.sv
module acc_datapath_chk
  import cpu_dp_pkg::*;
(
  input logic                            clk,
  input logic                            rst_n,
  input logic [INSTR_W-1:0]              instr,
  input logic                            a_wr,
  input logic                            b_wr,
  input logic [DATA_W-1:0]               bus_a,
  input logic [DATA_W-1:0]               bus_b,
  input logic                            mem_we,
  input logic                            ev_a_write,
  input logic                            ev_b_write,
  input logic [NUM_REGS-1:0][DATA_W-1:0] reg_view
);

  logic [OPC_W-1:0] op;
  logic [SEL_W-1:0] sa, sb;
  assign op = instr[INSTR_W-1:OPC_LSB];
  assign sa = instr[OPC_LSB-1:SELA_LSB];
  assign sb = instr[SELA_LSB-1:SELB_LSB];

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (reg_view == '0));

  a_r8_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_wr && b_wr));

  a_r8_a_commit: assert property (@(posedge clk) disable iff (!rst_n)
    ev_a_write |=> (reg_view[$past(sa)] == $past(bus_a)));

  a_r8_b_commit: assert property (@(posedge clk) disable iff (!rst_n)
    ev_b_write |=> (reg_view[$past(sb)] == $past(bus_b)));

  a_r4_store_only: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (op == 5'd5 || op == 5'd6 || op == 5'd7));

  a_r9_branch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (op >= 5'd11 || op == 5'd0) |-> (!a_wr && !b_wr && !mem_we));

  a_r9_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_wr && !b_wr) |=> $stable(reg_view));

  a_r5_movd_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (b_wr && op == 5'd4) |-> (bus_b[DATA_W-1] == 1'b0));

  a_r7_sl_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr && op == 5'd10) |-> (bus_a[0] == 1'b0));

  a_r7_sr_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr && op == 5'd9) |-> (bus_a[DATA_W-1] == 1'b0));

endmodule

bind acc_datapath acc_datapath_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .instr      (instr),
  .a_wr       (a_wr),
  .b_wr       (b_wr),
  .bus_a      (bus_a),
  .bus_b      (bus_b),
  .mem_we     (mem_we),
  .ev_a_write (ev_a_write),
  .ev_b_write (ev_b_write),
  .reg_view   (reg_view)
);

// File: tb/acc_datapath_test.sv
module acc_datapath_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] instr = '0;
  logic [14:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, bus_a, bus_b;
  logic        mem_we, mem_re, a_wr, b_wr, b_is_zero;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench-side memory, 1024 words, with a preload port
  logic [15:0] mem [1024];
  logic        pre_we = 1'b0;
  logic [9:0]  pre_addr = '0;
  logic [15:0] pre_data = '0;

  always #4 clk = ~clk;  // 125 MHz

  always_ff @(posedge clk) begin
    if (mem_we)      mem[mem_addr[9:0]] <= mem_wdata;
    else if (pre_we) mem[pre_addr]      <= pre_data;
  end
  assign mem_rdata = mem[mem_addr[9:0]];

  acc_datapath uut (
    .clk(clk), .rst_n(rst_n), .instr(instr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .bus_a(bus_a), .bus_b(bus_b),
    .a_wr(a_wr), .b_wr(b_wr), .b_is_zero(b_is_zero)
  );

  function automatic logic [23:0] mk(input int op, input int ra, input int rb, input int imm);
    return {op[4:0], ra[1:0], rb[1:0], imm[14:0]};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // present one instruction; returns in the sampling window before its commit edge
  task automatic exec(input logic [23:0] w);
    @(negedge clk);
    instr = w;
    #3;
  endtask

  task automatic read_reg(input int idx, output logic [15:0] v);
    exec(mk(0, idx, 0, 0));
    v = bus_a;
  endtask

  task automatic set_reg(input int idx, input logic [15:0] val);
    @(negedge clk);
    instr = '0; pre_we = 1'b1; pre_addr = 10'h3F0; pre_data = val;
    @(negedge clk);
    pre_we = 1'b0;
    exec(mk(1, idx, 0, 'h3F0));
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int i = 0; i < 4; i++) begin
      read_reg(i, v);
      chk("R1 reset value", v, 16'h0000);
    end
    chk("R9 b_is_zero after reset", {15'd0, b_is_zero}, 16'h0001);
  endtask

  task automatic t_moves();
    logic [15:0] v;
    exec(mk(4, 0, 1, 'h7ABC));
    chk("R8 b_wr on MOVD", {14'd0, a_wr, b_wr}, 16'h0001);
    chk("R8 bus_b carries MOVD data", bus_b, 16'h7ABC);
    read_reg(1, v);
    chk("R5 MOVD zero-extended", v, 16'h7ABC);
    exec(mk(3, 1, 2, 0));
    chk("R8 b_wr on MOV", {14'd0, a_wr, b_wr}, 16'h0001);
    read_reg(2, v);
    chk("R5 MOV copies A into B", v, 16'h7ABC);
    set_reg(3, 16'h8123);
    exec(mk(0, 3, 2, 0));
    chk("R2 bus_a shows A select", bus_a, 16'h8123);
    chk("R2 bus_b shows B select", bus_b, 16'h7ABC);
    chk("R9 b_is_zero low for nonzero B", {15'd0, b_is_zero}, 16'h0000);
  endtask

  task automatic t_loads();
    logic [15:0] v;
    set_reg(0, 16'h8001);
    read_reg(0, v);
    chk("R3 LD immediate address", v, 16'h8001);
    @(negedge clk); instr = '0; pre_we = 1'b1; pre_addr = 10'h010; pre_data = 16'hBEEF;
    @(negedge clk); pre_we = 1'b0;
    exec(mk(4, 0, 3, 'h0010));
    exec(mk(2, 2, 3, 0));
    chk("R3 LDR mem_re", {15'd0, mem_re}, 16'h0001);
    chk("R8 a_wr on LDR", {14'd0, a_wr, b_wr}, 16'h0002);
    read_reg(2, v);
    chk("R3 LDR address from B", v, 16'hBEEF);
    set_reg(3, 16'h8010);
    exec(mk(2, 1, 3, 0));
    chk("R10 B bit 15 ignored in address", {1'b0, mem_addr}, 16'h0010);
    read_reg(1, v);
    chk("R10 LDR with B bit 15 set", v, 16'hBEEF);
  endtask

  task automatic t_stores();
    exec(mk(4, 0, 3, 'h0020));
    exec(mk(5, 0, 3, 'h1234));
    chk("R4 mem_we on ST", {15'd0, mem_we}, 16'h0001);
    chk("R8 no register write on ST", {14'd0, a_wr, b_wr}, 16'h0000);
    exec(mk(0, 0, 0, 0));
    chk("R4 ST immediate to address B", mem[10'h020], 16'h1234);
    exec(mk(4, 0, 3, 'h0021));
    exec(mk(6, 0, 3, 0));
    exec(mk(0, 0, 0, 0));
    chk("R4 STR A to address B", mem[10'h021], 16'h8001);
    exec(mk(7, 0, 2, 'h0030));
    exec(mk(0, 0, 0, 0));
    chk("R4 STD A to immediate address", mem[10'h030], 16'h8001);
  endtask

  task automatic t_alu();
    logic [15:0] v;
    logic [15:0] a0, b0, exp;
    a0 = 16'hF0F0; b0 = 16'h0FF5;
    for (int fn = 0; fn < 8; fn++) begin
      set_reg(0, a0);
      set_reg(1, b0);
      exec(mk(8, 0, 1, fn | 'h7FF8));  // upper function bits set: must not matter
      case (fn)
        0: exp = 16'h00E5;
        1: exp = 16'hE0FB;
        2: exp = 16'h00F0;
        3: exp = 16'hFFF5;
        4: exp = 16'hFF05;
        5: exp = 16'h0F0F;
        default: exp = a0;
      endcase
      read_reg(0, v);
      chk($sformatf("R6 ALU fn %0d", fn), v, exp);
    end
    read_reg(1, v);
    chk("R6 B unchanged by ALU", v, b0);
  endtask

  task automatic t_shift();
    logic [15:0] v;
    set_reg(2, 16'h8001);
    exec(mk(9, 2, 0, 0));
    chk("R7 SR on bus_a", bus_a, 16'h4000);
    read_reg(2, v);
    chk("R7 SR zero fill", v, 16'h4000);
    set_reg(2, 16'h8001);
    exec(mk(10, 2, 0, 0));
    read_reg(2, v);
    chk("R7 SL zero fill", v, 16'h0002);
  endtask

  task automatic t_quiet();
    logic [15:0] v;
    int ops[9] = '{0, 11, 12, 13, 14, 15, 16, 20, 31};
    set_reg(0, 16'h1111);
    set_reg(1, 16'h0000);
    foreach (ops[k]) begin
      exec(mk(ops[k], 0, 1, 'h0040));
      chk($sformatf("R9 strobes idle op %0d", ops[k]),
          {13'd0, a_wr, b_wr, mem_we}, 16'h0000);
      chk($sformatf("R9 b_is_zero op %0d", ops[k]), {15'd0, b_is_zero}, 16'h0001);
    end
    read_reg(0, v);
    chk("R9 A unchanged after branches", v, 16'h1111);
    read_reg(1, v);
    chk("R9 B unchanged after branches", v, 16'h0000);
  endtask

  initial begin
    #(8 * 50000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_moves();
    t_loads();
    t_stores();
    t_alu();
    t_shift();
    t_quiet();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule